// File: doc/BRIEF.md
# Compare and Condition-Field Generator

This block turns a compare, or an implicit compare of a result against zero, into a 4-bit condition field. The field is ready for a condition register to store. A caller supplies two 32-bit operands, a 16-bit immediate, a 3-bit operation select, the current summary-overflow flag and a 3-bit destination field index. It pulses `in_valid` for one cycle. One clock later the block raises `out_valid` for one cycle. At the same time it presents the field index and the field value that storage should write.

All orderings come from one unsigned comparator. That comparator reads the carry out of `~lhs + rhs`. Signed compares first flip the most significant bit of both operands, which maps two's-complement order onto unsigned order. The record form compares the first operand against zero as a signed value. The record form always targets field 0.

Top module: `cmp_field_gen`

## Requirements
- R1: A written field carries the less-than flag in bit 3, greater-than in bit 2 and equal in bit 1. Exactly one of these three bits is set.
- R2: Bit 0 of the written field equals `so_flag` as sampled in the cycle `in_valid` was high.
- R3: Op code 0 compares `opnd_a` with `opnd_b` as signed 32-bit two's-complement values.
- R4: Op code 1 compares `opnd_a` signed against `imm` sign-extended from 16 to 32 bits.
- R5: Op code 2 compares `opnd_a` with `opnd_b` as unsigned values.
- R6: Op code 3 compares `opnd_a` unsigned against `imm` zero-extended to 32 bits.
- R7: Op code 4 (record form) compares `opnd_a` against zero, taken as signed. It writes field index 0 regardless of `dest_idx`. The values of `opnd_b` and `imm` have no effect.
- R8: Equal operands give the equal flag only, never an ordering flag. Equality takes priority over ordering.
- R9: `out_valid` is high for exactly one cycle, in the cycle after an accepted `in_valid`. For op codes 0 to 3, `out_idx` equals the `dest_idx` given with the request.
- R10: Op codes 5, 6 and 7 produce no `out_valid`.
- R11: After reset, `out_valid`, `out_idx` and `out_field` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation: 0 signed reg, 1 signed imm, 2 unsigned reg, 3 unsigned imm, 4 record |
| opnd_a | input | 32 | First operand, or the result for record form |
| opnd_b | input | 32 | Second register operand |
| imm | input | 16 | Immediate operand |
| so_flag | input | 1 | Current summary-overflow flag |
| dest_idx | input | 3 | Destination field index for compare ops |
| out_valid | output | 1 | Field write enable, one-cycle pulse |
| out_idx | output | 3 | Field index to write |
| out_field | output | 4 | Field value {LT, GT, EQ, SO} |

## Verification
The block has one register stage, so an internal fault shows at the ports in the cycle right after the request. A wrong bias or a wrong immediate extension swaps LT and GT. This shows only on operands whose top bits differ, such as 0x7FFFFFFF against 0x80000000, or 0 against 0xFFFFFFFF. A wrong equality priority shows up as two flags set together. A stuck index or pulse shows up as a write to the wrong field, or as a second write cycle.

// File: rtl/cmpf_pkg.sv
package cmpf_pkg;
  typedef enum logic [2:0] {
    OP_SREG = 3'd0,
    OP_SIMM = 3'd1,
    OP_UREG = 3'd2,
    OP_UIMM = 3'd3,
    OP_REC  = 3'd4
  } cmpf_op_e;

  localparam int FLD_LT = 3;
  localparam int FLD_GT = 2;
  localparam int FLD_EQ = 1;
  localparam int FLD_SO = 0;
  localparam int FLD_W  = 4;
endpackage

// File: rtl/cmpf_operand_sel.sv
module cmpf_operand_sel
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  cmpf_op_e            op,
  input  logic [DATA_W-1:0]   a,
  input  logic [DATA_W-1:0]   b,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   lhs,
  output logic [DATA_W-1:0]   rhs,
  output logic                signed_mode
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam logic [DATA_W-1:0] SIGN_BIAS = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic logic [DATA_W-1:0] f_sext(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  function automatic logic [DATA_W-1:0] f_zext(input logic [IMM_W-1:0] v);
    return {{EXT_W{1'b0}}, v};
  endfunction

  logic [DATA_W-1:0] rhs_raw;
  logic [DATA_W-1:0] bias;

  always_comb begin
    case (op)
      OP_SREG, OP_UREG: rhs_raw = b;
      OP_SIMM:          rhs_raw = f_sext(imm);
      OP_UIMM:          rhs_raw = f_zext(imm);
      default:          rhs_raw = '0;
    endcase
    signed_mode = (op == OP_SREG) || (op == OP_SIMM) || (op == OP_REC);
    bias = signed_mode ? SIGN_BIAS : '0;
    lhs  = a ^ bias;
    rhs  = rhs_raw ^ bias;
  end
endmodule

// File: rtl/cmpf_carry_cmp.sv
module cmpf_carry_cmp #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic              lt,
  output logic              eq
);
  function automatic logic f_carry_lt(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y);
    logic [DATA_W:0] s;
    s = {1'b0, ~x} + {1'b0, y};
    return s[DATA_W];
  endfunction

  always_comb begin
    lt = f_carry_lt(lhs, rhs);
    eq = ~|(lhs ^ rhs);
  end

  always_comb begin
    if (eq) AST_EQ_EXCLUDES_LT: assert (!lt); // R8
  end
endmodule

// File: rtl/cmpf_field_enc.sv
module cmpf_field_enc
  import cmpf_pkg::*;
(
  input  logic             lt,
  input  logic             eq,
  input  logic             so,
  output logic [FLD_W-1:0] field
);
  always_comb begin
    field = '0;
    field[FLD_SO] = so;
    if (eq)      field[FLD_EQ] = 1'b1;
    else if (lt) field[FLD_LT] = 1'b1;
    else         field[FLD_GT] = 1'b1;
  end
endmodule

// File: rtl/cmp_field_gen.sv
module cmp_field_gen
  import cmpf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              so_flag,
  input  logic [IDX_W-1:0]  dest_idx,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [FLD_W-1:0]  out_field
);
  cmpf_op_e          op;
  logic              op_legal;
  logic              accept;
  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic              signed_mode;
  logic              cmp_lt;
  logic              cmp_eq;
  logic [FLD_W-1:0]  field_nxt;
  logic [IDX_W-1:0]  idx_nxt;

  assign op       = cmpf_op_e'(op_sel);
  assign op_legal = (op_sel <= 3'(OP_REC));
  assign accept   = in_valid && op_legal;
  assign idx_nxt  = (op == OP_REC) ? '0 : dest_idx;

  cmpf_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .op(op), .a(opnd_a), .b(opnd_b), .imm(imm),
    .lhs(lhs), .rhs(rhs), .signed_mode(signed_mode)
  );

  cmpf_carry_cmp #(.DATA_W(DATA_W)) u_cmp (
    .lhs(lhs), .rhs(rhs), .lt(cmp_lt), .eq(cmp_eq)
  );

  cmpf_field_enc u_enc (
    .lt(cmp_lt), .eq(cmp_eq), .so(so_flag), .field(field_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_field <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_idx   <= idx_nxt;
        out_field <= field_nxt;
      end
    end
  end

  AST_ONE_ORDER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_field[FLD_LT:FLD_EQ]) == 1); // R1
  AST_SO_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_field[FLD_SO] == $past(so_flag)); // R2
  AST_REC_FIELD0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'(OP_REC)) |=> out_idx == '0); // R7
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel > 3'(OP_REC)) |=> !out_valid); // R10
  AST_REC_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 3'(OP_REC)) |-> signed_mode); // R7
endmodule

// File: tb/cmp_field_gen_tb.sv
module cmp_field_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [15:0] imm = '0;
  logic        so_flag = 1'b0;
  logic [2:0]  dest_idx = '0;
  logic        out_valid;
  logic [2:0]  out_idx;
  logic [3:0]  out_field;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_field_gen u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .so_flag(so_flag),
    .dest_idx(dest_idx), .out_valid(out_valid), .out_idx(out_idx),
    .out_field(out_field)
  );

  // {op, a, b, imm}
  localparam logic [82:0] VEC [NV] = '{
    {3'd0, 32'h7FFFFFFF, 32'h80000000, 16'h0000},
    {3'd0, 32'h80000000, 32'h7FFFFFFF, 16'h0000},
    {3'd0, 32'hFFFFFFFF, 32'h00000000, 16'h0000},
    {3'd0, 32'h00000005, 32'h00000005, 16'h0000},
    {3'd2, 32'hFFFFFFFF, 32'h00000000, 16'h0000},
    {3'd2, 32'h00000000, 32'hFFFFFFFF, 16'h0000},
    {3'd2, 32'h80000000, 32'h7FFFFFFF, 16'h0000},
    {3'd2, 32'h00001234, 32'h00001234, 16'h0000},
    {3'd1, 32'hFFFFFFFF, 32'h00000000, 16'hFFFF},
    {3'd1, 32'h00000000, 32'h00000000, 16'h8000},
    {3'd1, 32'h7FFFFFFF, 32'h00000000, 16'h7FFF},
    {3'd3, 32'h0000FFFF, 32'h00000000, 16'hFFFF},
    {3'd3, 32'hFFFFFFFF, 32'h00000000, 16'h8000},
    {3'd3, 32'h00000000, 32'h00000000, 16'h0001},
    {3'd4, 32'h00000000, 32'h12345678, 16'hABCD},
    {3'd4, 32'h80000000, 32'hFFFFFFFF, 16'h0000},
    {3'd4, 32'h7FFFFFFF, 32'h80000000, 16'hFFFF},
    {3'd4, 32'hFFFFFFFF, 32'h00000000, 16'h7FFF}
  };

  function automatic logic [2:0] order3(input longint x, input longint y);
    if (x == y) return 3'b001;
    if (x < y)  return 3'b100;
    return 3'b010;
  endfunction

  function automatic logic [3:0] model(input logic [2:0] op, input logic [31:0] a,
                                       input logic [31:0] b, input logic [15:0] im,
                                       input logic so);
    longint sa, sb, ua, ub;
    sa = longint'($signed(a));
    ua = longint'({32'h0, a});
    case (op)
      3'd0: begin sb = longint'($signed(b)); return {order3(sa, sb), so}; end
      3'd1: begin sb = longint'($signed(im)); return {order3(sa, sb), so}; end
      3'd2: begin ub = longint'({32'h0, b}); return {order3(ua, ub), so}; end
      3'd3: begin ub = longint'({48'h0, im}); return {order3(ua, ub), so}; end
      default: return {order3(sa, 0), so};
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic request(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic so, input logic [2:0] idx);
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; imm = im;
    so_flag = so; dest_idx = idx;
    @(negedge clk);
    in_valid = 1'b0; so_flag = ~so;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] exp_f;
    logic [2:0] exp_i;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_idx == 3'd0 && out_field == 4'd0, "R11 reset",
          {out_valid, out_idx, out_field}, 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      op = VEC[i][82:80];
      request(op, VEC[i][79:48], VEC[i][47:16], VEC[i][15:0], i[0], 3'(i + 3));
      exp_f = model(op, VEC[i][79:48], VEC[i][47:16], VEC[i][15:0], i[0]);
      exp_i = (op == 3'd4) ? 3'd0 : 3'(i + 3);
      check(out_valid, "R9 valid", 32'(out_valid), 32'd1);
      check(out_field == exp_f, {req_of(op), " R1 R2 R8 field"}, 32'(out_field), 32'(exp_f));
      check(out_idx == exp_i, (op == 3'd4) ? "R7 idx" : "R9 idx", 32'(out_idx), 32'(exp_i));
      @(negedge clk);
      check(!out_valid, "R9 pulse", 32'(out_valid), 32'd0);
    end

    // R7: record form ignores b and imm, forces field 0
    request(3'd4, 32'h00000001, 32'hFFFFFFFF, 16'h8000, 1'b1, 3'd5);
    check(out_field == 4'b0101 && out_idx == 3'd0, "R7 ignore",
          {out_idx, out_field}, {3'd0, 4'b0101});

    // R8: equality beats ordering at the sign boundary
    request(3'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b0, 3'd2);
    check(out_field == 4'b0010, "R8 eq", 32'(out_field), 32'h2);

    // R2: summary overflow copied at both values
    request(3'd2, 32'h1, 32'h2, 16'h0, 1'b1, 3'd1);
    check(out_field == 4'b1001, "R2 so1", 32'(out_field), 32'h9);
    request(3'd2, 32'h1, 32'h2, 16'h0, 1'b0, 3'd1);
    check(out_field == 4'b1000, "R2 so0", 32'(out_field), 32'h8);

    // R10: illegal op codes produce no write
    for (int k = 5; k < 8; k++) begin
      request(3'(k), 32'h0, 32'h0, 16'h0, 1'b0, 3'd6);
      check(!out_valid && out_idx == 3'd1, "R10 illegal", {out_valid, out_idx}, 32'h1);
    end

    // R9: back-to-back requests each give one write
    @(negedge clk);
    in_valid = 1'b1; op_sel = 3'd0; opnd_a = 32'h3; opnd_b = 32'h4; dest_idx = 3'd7; so_flag = 1'b0;
    @(negedge clk);
    check(out_valid && out_field == 4'b1000 && out_idx == 3'd7, "R9 b2b first",
          {out_valid, out_idx, out_field}, {1'b1, 3'd7, 4'b1000});
    opnd_a = 32'h4; opnd_b = 32'h3; dest_idx = 3'd6;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_field == 4'b0100 && out_idx == 3'd6, "R9 b2b second",
          {out_valid, out_idx, out_field}, {1'b1, 3'd6, 4'b0100});
    @(negedge clk);
    check(!out_valid, "R9 b2b end", 32'(out_valid), 32'd0);

    // R11: reset clears a written state
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_idx == 3'd0 && out_field == 4'd0, "R11 re-reset",
          {out_valid, out_idx, out_field}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule